// File: doc/BRIEF.md
# Receiver Address Match Filter

This block sits between a serial receiver's character output and the receive data buffer. In a multi-drop link, characters with their top bit set carry node addresses and the others carry payload. The filter passes on only the traffic meant for this node.

Two programmable 8-bit match values are held, and each has its own enable. An address character is compared against every enabled match value. The result opens or closes a gate that stays set for the payload that follows, until the next address character arrives. When both enables are clear, the filter is transparent. A small register port lets software set up the match values and the enables at any time, including while characters are arriving.

Top module: `addr_match_filter`

## Requirements
- R1: A received character is an address character only when bit 7 is 1; a character with bit 7 equal to 0 never changes the gate state.
- R2: Register index 0 holds match value A and index 1 holds match value B. Index 2 holds the enables: bit 0 enables A and bit 1 enables B. An address character matches only when all 8 bits, including bit 7, are equal to the value of an enabled register.
- R3: A matching address character is forwarded, and it opens the gate. Data characters that follow are forwarded until the next address character.
- R4: A non-matching address character is dropped, and it closes the gate. Data characters that follow are dropped.
- R5: While both enables are 0, every character is forwarded unchanged, and the gate state is left as it was.
- R6: After reset, both match values and the enables read 0, the gate is closed, and `out_valid` is 0. With filtering enabled, data arriving before any address character is dropped.
- R7: Each register reads back its last written value at any time, with no wait state. A write in the same cycle as a received character takes effect only for later characters.
- R8: `out_valid` is a one-cycle pulse issued one clock after the accepted `rx_valid`. `out_data` carries that character and holds it until the next forwarded character.
- R9: `match_open` shows the gate state, and it updates one clock after an address character is received while filtering is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| reg_wr | input | 1 | Register write enable |
| reg_idx | input | 2 | Register index (0 match A, 1 match B, 2 enables) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_idx`, combinational |
| out_valid | output | 1 | Forwarded character strobe |
| out_data | output | 8 | Forwarded character |
| match_open | output | 1 | Gate state: 1 while payload is being accepted |

## Verification
The assertions check timing and locality on every cycle:
- `out_valid` only ever follows a received character.
- Bypass mode copies the input through.
- Payload never moves the gate.
- A closed gate drops payload.
- The gate holds while nothing arrives.

Only the bench scenarios can show the rest:
- The compare sees all 8 bits, so a stored value without bit 7 never matches.
- A disabled register is ignored.
- A write in the same cycle as a character is seen only by later comparisons.
- The gate state survives a spell of bypass.

// File: rtl/addr_match_filter.sv
module addr_match_filter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  input  logic         reg_wr,
  input  logic [1:0]   reg_idx,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         match_open
);

  logic [W-1:0] match_a, match_b;
  logic [1:0]   en;

  wire filt    = |en;
  wire is_addr = rx_data[W-1];
  wire hit     = (en[0] && rx_data == match_a) || (en[1] && rx_data == match_b);
  wire pass    = !filt || (is_addr ? hit : match_open);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_a <= '0;
      match_b <= '0;
      en      <= '0;
    end else if (reg_wr) begin
      case (reg_idx)
        2'd0:    match_a <= reg_wdata;
        2'd1:    match_b <= reg_wdata;
        2'd2:    en      <= reg_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_idx)
      2'd0:    reg_rdata = match_a;
      2'd1:    reg_rdata = match_b;
      2'd2:    reg_rdata = {{(W-2){1'b0}}, en};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      match_open <= 1'b0;
    else if (rx_valid && filt && is_addr)
      match_open <= hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= rx_valid && pass;
      if (rx_valid && pass) out_data <= rx_data;
    end
  end

  // R8: a forwarded strobe always follows a received character
  a_r8_follows_rx: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(rx_valid));

  // R5: bypass copies every character through
  a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && en == 2'b00) |=> (out_valid && out_data == $past(rx_data)));

  // R1: payload characters never move the gate
  a_r1_data_keeps_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_data[W-1]) |=> $stable(match_open));

  // R4: closed gate drops payload
  a_r4_closed_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_data[W-1] && en != 2'b00 && !match_open) |=> !out_valid);

  // R9: gate holds while nothing arrives
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> ($stable(match_open) && !out_valid));

endmodule

// File: tb/sim_addr_match_filter.sv
module sim_addr_match_filter;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, reg_wr = 0;
  logic [7:0] rx_data = 0, reg_wdata = 0;
  logic [1:0] reg_idx = 0;
  logic [7:0] reg_rdata, out_data;
  logic out_valid, match_open;

  always #5 clk = ~clk;

  addr_match_filter u0 (.clk, .rst_n, .rx_valid, .rx_data, .reg_wr, .reg_idx,
    .reg_wdata, .reg_rdata, .out_valid, .out_data, .match_open);

  int checks = 0, fails = 0;
  bit done = 0;
  // behavioural model
  logic [7:0] m_a = 0, m_b = 0, m_last = 0;
  logic [1:0] m_en = 0;
  bit m_open = 0, m_v = 0;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle, advance the model, compare at the next negedge
  task automatic step(bit v, logic [7:0] d, bit wr, logic [1:0] idx, logic [7:0] wd, string req);
    bit fwd, is_hit;
    rx_valid = v; rx_data = d; reg_wr = wr; reg_idx = idx; reg_wdata = wd;
    @(posedge clk);
    is_hit = (m_en[0] && d == m_a) || (m_en[1] && d == m_b);
    if (m_en == 0) fwd = 1;
    else if (d[7]) fwd = is_hit;
    else fwd = m_open;
    m_v = v && fwd;
    if (m_v) m_last = d;
    if (v && m_en != 0 && d[7]) m_open = is_hit;
    if (wr) begin
      if (idx == 0) m_a = wd;
      else if (idx == 1) m_b = wd;
      else if (idx == 2) m_en = wd[1:0];
    end
    @(negedge clk);
    chk({req, " out_valid"}, {7'b0, out_valid}, {7'b0, m_v});
    chk({req, " out_data R8"}, out_data, m_last);
    chk({req, " match_open R9"}, {7'b0, match_open}, {7'b0, m_open});
    chk({req, " reg_rdata R7"}, reg_rdata,
        idx == 0 ? m_a : idx == 1 ? m_b : idx == 2 ? {6'b0, m_en} : 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6 out_valid", {7'b0, out_valid}, 0);
    chk("R6 match_open", {7'b0, match_open}, 0);
    chk("R6 match A", reg_rdata, 0);
    rst_n = 1;
    step(0, 0, 0, 1, 0, "R6 match B");
    step(0, 0, 0, 2, 0, "R6 enables");
    // R5 bypass, including an address character
    step(1, 8'h11, 0, 0, 0, "R5 data");
    step(1, 8'hF3, 0, 0, 0, "R5 addr");
    // enable A, data before any address dropped
    step(0, 0, 1, 2, 8'h01, "R7 en write");
    step(1, 8'h22, 0, 2, 0, "R6 early data");
    step(0, 0, 1, 0, 8'h85, "R7 write A");
    // R3 match then data
    step(1, 8'h85, 0, 0, 0, "R3 addr");
    step(1, 8'h12, 0, 0, 0, "R3 data1");
    step(0, 0, 0, 0, 0, "R3 gap");
    step(1, 8'h34, 0, 0, 0, "R3 data2");
    // R4 mismatch
    step(1, 8'h86, 0, 0, 0, "R4 addr");
    step(1, 8'h56, 0, 0, 0, "R4 data");
    // R2: B value set but disabled is ignored
    step(0, 0, 1, 1, 8'h86, "R2 write B");
    step(1, 8'h86, 0, 1, 0, "R2 B disabled");
    step(0, 0, 1, 2, 8'h03, "R2 enable B");
    step(1, 8'h86, 0, 2, 0, "R2 B match");
    step(1, 8'h07, 0, 0, 0, "R2 data");
    // R2 full 8-bit compare: stored 0x05 never equals 0x85
    step(0, 0, 1, 0, 8'h05, "R2 A=05");
    step(1, 8'h85, 0, 0, 0, "R2 top bit compare");
    step(1, 8'h41, 0, 0, 0, "R2 dropped data");
    // R7 same-cycle write affects later only
    step(1, 8'h90, 1, 0, 8'h90, "R7 same cycle");
    step(1, 8'h42, 0, 0, 0, "R7 data dropped");
    step(1, 8'h90, 0, 0, 0, "R7 next addr");
    step(1, 8'h43, 0, 0, 0, "R7 data fwd");
    // R5 bypass keeps gate state, then resumes
    step(0, 0, 1, 2, 8'h00, "R5 disable");
    step(1, 8'h99, 0, 0, 0, "R5 addr bypass");
    step(1, 8'h01, 0, 0, 0, "R5 data bypass");
    step(0, 0, 1, 2, 8'h02, "R5 enable B only");
    step(1, 8'h44, 0, 0, 0, "R1 gate kept");
    step(1, 8'h90, 0, 0, 0, "R2 A disabled");
    step(1, 8'h45, 0, 0, 0, "R1 data after miss");
    step(0, 0, 0, 3, 0, "R7 idx3");
    finish_run();
  end
endmodule